// File: doc/BRIEF.md
# Store Buffer with Ordering Fences

This block holds retired stores between a processor core and its data cache. A store that the core has committed is parked in a small buffer and written to memory in the background, one entry per cycle over a valid/ready handshake. The core keeps issuing loads while these writes are pending. A load to an address held in the buffer takes its value from the youngest matching entry. A load that matches nothing is released at once to fetch from memory, ahead of the older buffered stores.

Two mode inputs set the ordering policy. The drain mode chooses strict program order, or an out-of-order policy in which the lowest-numbered eligible slot is written first. A no-forward mode makes loads that hit the buffer wait until the matching store has reached memory. The core can also issue typed fences, which hold back only the class of operation that they order.

Top module: `stbuf_top`

## Requirements
- R1: After reset the buffer is empty: `st_ready` and `ld_ready` are 1, `mem_valid` and `ld_rsp_valid` are 0.
- R2: A store is accepted when `st_valid` and `st_ready` are both high. `st_ready` is low whenever all DEPTH entries are occupied, and no accepted entry is ever lost or overwritten.
- R3: A load is accepted when `ld_valid` and `ld_ready` are both high. In the next cycle `ld_rsp_valid` is 1. If the address matched a buffered store, `ld_rsp_fwd` is 1 and `ld_rsp_data` is the data of the youngest matching store.
- R4: An accepted load that matches no buffered store answers with `ld_rsp_fwd`=0 and `ld_rsp_data`=0, meaning "read memory", even while older stores are still buffered.
- R5: With `mode_ooo`=0, stores appear on `mem_addr`/`mem_data` in the order in which they were accepted.
- R6: With `mode_ooo`=1, the eligible store in the lowest slot index drains first. A new store takes the lowest free slot.
- R7: In every mode, two buffered stores to the same address drain in their acceptance order.
- R8: A write-read fence (`fence_kind`=1) is always accepted. After it, `ld_ready` stays low until every store buffered at the fence (including a store accepted in the same cycle) has drained.
- R9: After an accepted write-write fence (`fence_kind`=0), no store accepted later drains before all stores buffered at the fence have drained. A further write-write fence sees `fence_ready`=0 while that older group remains.
- R10: Read-read (`fence_kind`=2) and read-write (`fence_kind`=3) fences are accepted at once. They change neither `ld_ready` nor the drain order.
- R11: With `mode_nofwd`=1, a load whose address matches a buffered store sees `ld_ready`=0 until no buffered store matches. It is then answered with `ld_rsp_fwd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ooo | input | 1 | 0: drain in program order, 1: lowest eligible slot first |
| mode_nofwd | input | 1 | 1: loads that hit the buffer wait for the store to drain |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Buffer has a free entry |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Core offers a load lookup |
| ld_ready | output | 1 | Load may proceed this cycle |
| ld_addr | input | AW | Load address |
| ld_rsp_valid | output | 1 | Registered load answer valid |
| ld_rsp_fwd | output | 1 | 1: data comes from the buffer, 0: read memory |
| ld_rsp_data | output | DW | Forwarded data, 0 when not forwarded |
| fence_valid | input | 1 | Core issues a fence |
| fence_kind | input | 2 | 0 write-write, 1 write-read, 2 read-read, 3 read-write |
| fence_ready | output | 1 | Fence accepted this cycle |
| mem_valid | output | 1 | A store is offered to memory |
| mem_ready | input | 1 | Memory takes the offered store |
| mem_addr | output | AW | Address of the offered store |
| mem_data | output | DW | Data of the offered store |

## Verification
On every cycle the assertions check the following. A full buffer refuses stores. In program-order mode the offered store is the oldest one. No offered store has an older store to the same address still waiting. Every accepted load is answered one cycle later, and in no-forward mode that answer never comes from the buffer. A write-read fence accepted over several stores closes the load path. Some behaviours can only be shown by the bench's scenarios, because they depend on a reference order of events. These are which data value is the youngest match, the exact sequence of addresses leaving in each drain mode, a younger store held behind a write-write fence in a lower slot, and the reopening of the load path once the last fenced store has drained.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  typedef enum logic [1:0] {
    FENCE_WW = 2'd0,
    FENCE_WR = 2'd1,
    FENCE_RR = 2'd2,
    FENCE_RW = 2'd3
  } fence_kind_e;
endpackage

// File: rtl/stbuf_entries.sv
// Entry storage: valid bit, address, data and a relative age (0 = oldest).
module stbuf_entries #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [AW-1:0]            push_addr,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop,
  input  logic [IW-1:0]            pop_idx,
  output logic [DEPTH-1:0]         vld,
  output logic [DEPTH-1:0][AW-1:0] addr_q,
  output logic [DEPTH-1:0][DW-1:0] data_q,
  output logic [DEPTH-1:0][IW-1:0] age_q,
  output logic                     full,
  output logic [IW-1:0]            free_idx
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ;
  logic [IW-1:0] new_age;

  always_comb begin
    full     = &vld;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IW'(i);
    end
    occ     = CW'($countones(vld));
    new_age = IW'(occ - CW'(pop));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      age_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop && pop_idx == IW'(i)) begin
          vld[i] <= 1'b0;
        end else if (push && free_idx == IW'(i)) begin
          vld[i]   <= 1'b1;
          age_q[i] <= new_age;
        end else if (vld[i] && pop && age_q[i] > age_q[pop_idx]) begin
          age_q[i] <= age_q[i] - 1'b1;
        end
      end
    end
  end

  // payload written by index only, no reset
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[free_idx] <= push_addr;
      data_q[free_idx] <= push_data;
    end
  end
endmodule

// File: rtl/stbuf_drain_sel.sv
// Chooses which entry is offered to memory this cycle.
module stbuf_drain_sel #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]         vld,
  input  logic [DEPTH-1:0][AW-1:0] addr_q,
  input  logic [DEPTH-1:0][IW-1:0] age_q,
  input  logic                     mode_ooo,
  input  logic [DEPTH-1:0]         ww_mask,
  output logic                     sel_valid,
  output logic [IW-1:0]            sel_idx
);
  logic [DEPTH-1:0] blocked;
  logic [DEPTH-1:0] elig;
  logic             ww_pend;

  assign ww_pend = |ww_mask;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (vld[j] && addr_q[j] == addr_q[i] && age_q[j] < age_q[i])
          blocked[i] = 1'b1;
      end
      elig[i] = vld[i] && !blocked[i] && (!ww_pend || ww_mask[i]) &&
                (mode_ooo || age_q[i] == '0);
    end
    sel_valid = |elig;
    sel_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) sel_idx = IW'(i);
    end
  end
endmodule

// File: rtl/stbuf_fwd.sv
// Finds the youngest buffered store matching a load address.
module stbuf_fwd #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]         vld,
  input  logic [DEPTH-1:0][AW-1:0] addr_q,
  input  logic [DEPTH-1:0][DW-1:0] data_q,
  input  logic [DEPTH-1:0][IW-1:0] age_q,
  input  logic [AW-1:0]            ld_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);
  logic [IW-1:0] best_age;

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    best_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && addr_q[i] == ld_addr && (!hit || age_q[i] > best_age)) begin
        hit      = 1'b1;
        hit_data = data_q[i];
        best_age = age_q[i];
      end
    end
  end
endmodule

// File: rtl/stbuf_fence.sv
// Tracks the stores each pending fence is waiting on.
module stbuf_fence #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fence_valid,
  input  stbuf_pkg::fence_kind_e   fence_kind,
  input  logic [DEPTH-1:0]         resident_nxt,
  input  logic [DEPTH-1:0]         pop_oh,
  output logic                     fence_ready,
  output logic                     wr_pend,
  output logic [DEPTH-1:0]         ww_mask
);
  import stbuf_pkg::*;

  logic [DEPTH-1:0] wr_mask;
  logic             take;

  assign wr_pend     = |wr_mask;
  assign fence_ready = (fence_kind == FENCE_WW) ? ~|ww_mask : 1'b1;
  assign take        = fence_valid && fence_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_mask <= '0;
      ww_mask <= '0;
    end else begin
      if (take && fence_kind == FENCE_WR) wr_mask <= resident_nxt | (wr_mask & ~pop_oh);
      else                                wr_mask <= wr_mask & ~pop_oh;
      if (take && fence_kind == FENCE_WW) ww_mask <= resident_nxt;
      else                                ww_mask <= ww_mask & ~pop_oh;
    end
  end
endmodule

// File: rtl/stbuf_top.sv
module stbuf_top #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_ooo,
  input  logic          mode_nofwd,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_rsp_valid,
  output logic          ld_rsp_fwd,
  output logic [DW-1:0] ld_rsp_data,
  input  logic          fence_valid,
  input  logic [1:0]    fence_kind,
  output logic          fence_ready,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);
  import stbuf_pkg::*;

  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0]         vld;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0][IW-1:0] age_q;
  logic                     full;
  logic [IW-1:0]            free_idx;
  logic [IW-1:0]            sel_idx;
  logic                     sel_valid;
  logic                     push, pop;
  logic [DEPTH-1:0]         push_oh, pop_oh, resident_nxt;
  logic [DEPTH-1:0]         ww_mask;
  logic                     wr_pend;
  logic                     hit;
  logic [DW-1:0]            hit_data;

  assign st_ready  = !full;
  assign push      = st_valid && st_ready;
  assign mem_valid = sel_valid;
  assign pop       = sel_valid && mem_ready;
  assign mem_addr  = addr_q[sel_idx];
  assign mem_data  = data_q[sel_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_oh
    assign push_oh[g] = push && free_idx == IW'(g);
    assign pop_oh[g]  = pop && sel_idx == IW'(g);
  end
  assign resident_nxt = (vld | push_oh) & ~pop_oh;

  stbuf_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .IW(IW)) u_entries (
    .clk(clk), .rst(rst), .push(push), .push_addr(st_addr), .push_data(st_data),
    .pop(pop), .pop_idx(sel_idx), .vld(vld), .addr_q(addr_q), .data_q(data_q),
    .age_q(age_q), .full(full), .free_idx(free_idx)
  );

  stbuf_drain_sel #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_drain (
    .vld(vld), .addr_q(addr_q), .age_q(age_q), .mode_ooo(mode_ooo),
    .ww_mask(ww_mask), .sel_valid(sel_valid), .sel_idx(sel_idx)
  );

  stbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .IW(IW)) u_fwd (
    .vld(vld), .addr_q(addr_q), .data_q(data_q), .age_q(age_q),
    .ld_addr(ld_addr), .hit(hit), .hit_data(hit_data)
  );

  stbuf_fence #(.DEPTH(DEPTH)) u_fence (
    .clk(clk), .rst(rst), .fence_valid(fence_valid),
    .fence_kind(fence_kind_e'(fence_kind)), .resident_nxt(resident_nxt),
    .pop_oh(pop_oh), .fence_ready(fence_ready), .wr_pend(wr_pend), .ww_mask(ww_mask)
  );

  assign ld_ready = !wr_pend && !(mode_nofwd && hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_rsp_valid <= 1'b0;
      ld_rsp_fwd   <= 1'b0;
      ld_rsp_data  <= '0;
    end else begin
      ld_rsp_valid <= ld_valid && ld_ready;
      ld_rsp_fwd   <= ld_valid && ld_ready && hit;
      ld_rsp_data  <= (ld_valid && ld_ready && hit) ? hit_data : '0;
    end
  end
endmodule

// File: rtl/stbuf_chk.sv
module stbuf_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     mode_ooo,
  input logic                     mode_nofwd,
  input logic                     st_ready,
  input logic                     ld_valid,
  input logic                     ld_ready,
  input logic                     ld_rsp_valid,
  input logic                     ld_rsp_fwd,
  input logic                     fence_valid,
  input logic [1:0]               fence_kind,
  input logic                     fence_ready,
  input logic                     mem_valid,
  input logic [DEPTH-1:0]         vld,
  input logic [DEPTH-1:0][AW-1:0] addr_q,
  input logic [DEPTH-1:0][IW-1:0] age_q,
  input logic [IW-1:0]            sel_idx
);
  logic older_same;

  always_comb begin
    older_same = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (vld[j] && addr_q[j] == addr_q[sel_idx] && age_q[j] < age_q[sel_idx])
        older_same = 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ($countones(vld) == DEPTH) |-> !st_ready); // R2
  AST_LOAD_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready) |=> ld_rsp_valid); // R3
  AST_FIFO_OLDEST: assert property (@(posedge clk) disable iff (rst)
    (!mode_ooo && mem_valid) |-> (age_q[sel_idx] == '0)); // R5
  AST_SAME_ADDR_ORDER: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !older_same); // R7
  AST_WR_FENCE_STALL: assert property (@(posedge clk) disable iff (rst)
    (fence_valid && fence_ready && fence_kind == 2'd1 && $countones(vld) > 1) |=> !ld_ready); // R8
  AST_NOFWD_NO_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (mode_nofwd && ld_valid && ld_ready) |=> !ld_rsp_fwd); // R11
endmodule

bind stbuf_top stbuf_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mode_ooo(mode_ooo), .mode_nofwd(mode_nofwd),
  .st_ready(st_ready), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .ld_rsp_valid(ld_rsp_valid), .ld_rsp_fwd(ld_rsp_fwd),
  .fence_valid(fence_valid), .fence_kind(fence_kind), .fence_ready(fence_ready),
  .mem_valid(mem_valid), .vld(vld), .addr_q(addr_q), .age_q(age_q), .sel_idx(sel_idx)
);

// File: tb/stbuf_top_tb.sv
module stbuf_top_tb;
  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_ooo = 1'b0, mode_nofwd = 1'b0;
  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic          ld_rsp_valid, ld_rsp_fwd;
  logic [DW-1:0] ld_rsp_data;
  logic          fence_valid = 1'b0;
  logic [1:0]    fence_kind = 2'd0;
  logic          fence_ready;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  stbuf_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .mode_ooo(mode_ooo), .mode_nofwd(mode_nofwd),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_fwd(ld_rsp_fwd), .ld_rsp_data(ld_rsp_data),
    .fence_valid(fence_valid), .fence_kind(fence_kind), .fence_ready(fence_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic push_st(input logic [AW-1:0] a, input logic [DW-1:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    #1 chk("R2 st_ready", 64'(st_ready), 64'd1);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic drain_one(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    mem_ready = 1'b1;
    #1;
    chk({req, " mem_valid"}, 64'(mem_valid), 64'd1);
    chk({req, " mem_addr"}, 64'(mem_addr), 64'(a));
    chk({req, " mem_data"}, 64'(mem_data), 64'(d));
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  task automatic load(input logic [AW-1:0] a, input logic fwd, input logic [DW-1:0] d,
                      input string req);
    ld_valid = 1'b1; ld_addr = a;
    #1 chk({req, " ld_ready"}, 64'(ld_ready), 64'd1);
    @(negedge clk);
    ld_valid = 1'b0;
    #1;
    chk({req, " rsp_valid"}, 64'(ld_rsp_valid), 64'd1);
    chk({req, " rsp_fwd"}, 64'(ld_rsp_fwd), 64'(fwd));
    chk({req, " rsp_data"}, 64'(ld_rsp_data), 64'(d));
  endtask

  task automatic fence(input logic [1:0] k, input string req);
    fence_valid = 1'b1; fence_kind = k;
    #1 chk({req, " fence_ready"}, 64'(fence_ready), 64'd1);
    @(negedge clk);
    fence_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 st_ready", 64'(st_ready), 64'd1);
    chk("R1 ld_ready", 64'(ld_ready), 64'd1);
    chk("R1 mem_valid", 64'(mem_valid), 64'd0);
    chk("R1 rsp_valid", 64'(ld_rsp_valid), 64'd0);
  endtask

  task automatic t_fifo_fwd;
    mode_ooo = 1'b0;
    push_st(16'h0010, 32'hA1);
    push_st(16'h0020, 32'hB2);
    push_st(16'h0030, 32'hC3);
    load(16'h0020, 1'b1, 32'hB2, "R3");
    load(16'h0099, 1'b0, 32'h0, "R4");
    drain_one(16'h0010, 32'hA1, "R5");
    push_st(16'h0040, 32'hD4);
    drain_one(16'h0020, 32'hB2, "R5");
    drain_one(16'h0030, 32'hC3, "R5");
    drain_one(16'h0040, 32'hD4, "R5");
    #1 chk("R5 empty", 64'(mem_valid), 64'd0);
    @(negedge clk);
  endtask

  task automatic t_ooo;
    mode_ooo = 1'b1;
    push_st(16'h0010, 32'h11);
    push_st(16'h0020, 32'h22);
    push_st(16'h0030, 32'h33);
    drain_one(16'h0010, 32'h11, "R6");
    push_st(16'h0040, 32'h44);           // lands in slot 0
    drain_one(16'h0040, 32'h44, "R6");
    drain_one(16'h0020, 32'h22, "R6");
    drain_one(16'h0030, 32'h33, "R6");
  endtask

  task automatic t_same_addr;
    mode_ooo = 1'b1;
    push_st(16'h0040, 32'h01);
    push_st(16'h0050, 32'h02);
    drain_one(16'h0040, 32'h01, "R7");
    push_st(16'h0050, 32'h03);           // slot 0, younger than slot 1
    load(16'h0050, 1'b1, 32'h03, "R3 youngest");
    drain_one(16'h0050, 32'h02, "R7");
    drain_one(16'h0050, 32'h03, "R7");
  endtask

  task automatic t_full;
    mode_ooo = 1'b0;
    for (int i = 0; i < DEPTH; i++) push_st(AW'(16'h0100 + i), DW'(i * 3 + 7));
    st_valid = 1'b1; st_addr = 16'h0EEE; st_data = 32'hDEAD;
    #1 chk("R2 full st_ready", 64'(st_ready), 64'd0);
    st_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) drain_one(AW'(16'h0100 + i), DW'(i * 3 + 7), "R2");
  endtask

  task automatic t_wr_fence;
    mode_ooo = 1'b0;
    push_st(16'h0200, 32'h20);
    push_st(16'h0210, 32'h21);
    fence(2'd1, "R8");
    ld_valid = 1'b1; ld_addr = 16'h0300;
    #1 chk("R8 stalled", 64'(ld_ready), 64'd0);
    drain_one(16'h0200, 32'h20, "R8");
    #1 chk("R8 still stalled", 64'(ld_ready), 64'd0);
    drain_one(16'h0210, 32'h21, "R8");
    #1 chk("R8 released", 64'(ld_ready), 64'd1);
    @(negedge clk);
    ld_valid = 1'b0;
    #1 chk("R8 rsp_valid", 64'(ld_rsp_valid), 64'd1);
    @(negedge clk);
  endtask

  task automatic t_ww_fence;
    mode_ooo = 1'b1;
    push_st(16'h0400, 32'h40);
    push_st(16'h0410, 32'h41);
    push_st(16'h0420, 32'h42);
    drain_one(16'h0400, 32'h40, "R9");
    fence(2'd0, "R9");
    push_st(16'h0430, 32'h43);           // younger, slot 0
    fence_valid = 1'b1; fence_kind = 2'd0;
    #1 chk("R9 second fence", 64'(fence_ready), 64'd0);
    fence_valid = 1'b0;
    drain_one(16'h0410, 32'h41, "R9");
    drain_one(16'h0420, 32'h42, "R9");
    drain_one(16'h0430, 32'h43, "R9");
  endtask

  task automatic t_read_fences;
    mode_ooo = 1'b0;
    push_st(16'h0500, 32'h50);
    fence(2'd2, "R10 rr");
    fence(2'd3, "R10 rw");
    load(16'h0510, 1'b0, 32'h0, "R10");
    drain_one(16'h0500, 32'h50, "R10");
  endtask

  task automatic t_nofwd;
    mode_nofwd = 1'b1;
    push_st(16'h0600, 32'h66);
    ld_valid = 1'b1; ld_addr = 16'h0600;
    #1 chk("R11 hold", 64'(ld_ready), 64'd0);
    drain_one(16'h0600, 32'h66, "R11");
    #1 chk("R11 release", 64'(ld_ready), 64'd1);
    @(negedge clk);
    ld_valid = 1'b0;
    #1;
    chk("R11 rsp_valid", 64'(ld_rsp_valid), 64'd1);
    chk("R11 rsp_fwd", 64'(ld_rsp_fwd), 64'd0);
    mode_nofwd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1 t_reset();
    @(negedge clk);
    t_fifo_fwd();
    t_ooo();
    t_same_addr();
    t_full();
    t_wr_fence();
    t_ww_fence();
    t_read_fences();
    t_nofwd();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule